// File: doc/BRIEF.md
# Load/Store Issue-Order Tracker

This block keeps a record of the memory operations that are in flight inside an out-of-order core. It uses two independent slot pools, one for loads and one for stores. Each dispatched operation carries a program-order tag and three flags: reads memory, writes memory, and has side effects. The block accepts the operation only when every pool the operation needs has room. Once an operation is accepted, it holds one slot in each pool it touches until a completion for its tag arrives.

A scheduler asks about a tag and gets back one issue-permission bit in the same cycle. Permission follows a weak ordering model with four rules. Stores never overtake anything older. Loads may overtake older loads. A load overtakes older stores only when the compile-time no-alias option is set. An operation that reads memory and has side effects acts as a load fence, and it can only go once it is the oldest entry in the load pool. Address comparison, forwarding and cache behaviour lie outside the block.

Top module: `lsq_order_tracker`

## Requirements
- R1: After reset both pools are empty: `lq_empty` and `sq_empty` are 1, `lq_full` and `sq_full` are 0, and a query for any tag returns `qry_ready` = 0.
- R2: An accepted operation with the read flag takes one load slot. One with the write flag takes one store slot. One with both flags takes one slot in each pool. One with neither flag is accepted and takes no slot.
- R3: With a nonzero size parameter, a pool's full flag is 1 exactly when its occupancy equals that size. A size of 0 means the full flag never rises. A dispatch is rejected (`disp_accept` = 0) when any pool it needs has no free slot, and a rejected dispatch leaves both pools unchanged.
- R4: An operation that writes memory is not ready while any older tag holds a store slot.
- R5: An operation that writes memory is not ready while any older tag holds a load slot, whatever the no-alias setting.
- R6: A load is ready even when older plain loads are still outstanding.
- R7: With `NO_ALIAS` = 0, a load is not ready while an older store slot is held. With `NO_ALIAS` = 1, older stores do not hold it back.
- R8: An operation with both the read and the side-effect flags is a load fence. A load fence is ready only when no older tag holds a load slot. A younger load is not ready while an older load fence is still outstanding.
- R9: An operation with both the write and the side-effect flags is a store fence. It waits for all older stores and loads, and younger stores wait for it. An operation with all three flags obeys both the load-fence and the store-fence rules.
- R10: A completion frees every slot of its tag, in both pools, at the next clock edge. A completion for a tag that holds no slot changes nothing.
- R11: Age is decided by modular difference of the `TAG_W`-bit tags. Tag `a` is older than tag `b` when `(b - a) mod 2^TAG_W` is nonzero and below `2^(TAG_W-1)`, so tag 14 is older than tag 0 when `TAG_W` = 4.
- R12: A query for a tag that holds no slot in either pool returns `qry_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | A dispatch request is present |
| disp_tag | input | TAG_W | Program-order tag of the dispatched operation |
| disp_may_load | input | 1 | Operation reads memory |
| disp_may_store | input | 1 | Operation writes memory |
| disp_side_effect | input | 1 | Operation has side effects (makes it a fence) |
| disp_accept | output | 1 | Dispatch taken this cycle (combinational) |
| qry_tag | input | TAG_W | Tag whose issue permission is asked |
| qry_ready | output | 1 | Queried tag may issue (combinational) |
| done_valid | input | 1 | A completion is present |
| done_tag | input | TAG_W | Tag that has executed |
| lq_full | output | 1 | Load pool at its configured size |
| sq_full | output | 1 | Store pool at its configured size |
| lq_empty | output | 1 | No load slot held |
| sq_empty | output | 1 | No store slot held |

## Verification
`disp_accept` and `qry_ready` are combinational, so each is due in the same cycle as its stimulus. The pool flags, and the effect of a dispatch or completion on later answers, appear only after the next rising edge. The bench therefore drives every input on a falling edge and reads the combinational answers 2 ns later, before the rising edge. It reads the flags only after a further falling edge has passed. Two extra instances share all inputs: one with the no-alias option set and one with an unbounded load pool. This lets the alias rule and the size-zero rule be compared in the same cycle as the main instance.

// File: rtl/lsq_pkg.sv
// Shared helpers for the load/store order tracker.
// Assumes tags are issued in program order and that at most
// 2^(width-1) tags are in flight at once.
package lsq_pkg;

    // Returns 1 when tag a was issued before tag b (modular compare).
    function automatic logic tag_is_older(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input int unsigned width);
        logic [31:0] d;
        d = (b - a) & ((32'd1 << width) - 32'd1);
        return (d != 32'd0) && (d[width-1] == 1'b0);
    endfunction

endpackage

// File: rtl/lsq_slot_queue.sv
// One pool of tag slots. Each cycle it can allocate into the lowest free
// slot and clear every slot whose tag matches the completion tag.
// Assumes the caller allocates only when has_room_o is 1, and never
// allocates and frees the same tag in one cycle.
// SIZE = 0 selects an unbounded pool: the storage then covers the whole
// tag window and full_o stays low.
module lsq_slot_queue #(
    parameter int unsigned SIZE  = 4,
    parameter int unsigned TAG_W = 4,
    localparam int unsigned SLOTS = (SIZE == 0) ? (1 << (TAG_W - 1)) : SIZE,
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_en,
    input  logic [TAG_W-1:0]             alloc_tag,
    input  logic                         alloc_bar,
    input  logic                         free_en,
    input  logic [TAG_W-1:0]             free_tag,
    output logic [SLOTS-1:0]             valid_o,
    output logic [SLOTS-1:0][TAG_W-1:0]  tag_o,
    output logic [SLOTS-1:0]             bar_o,
    output logic                         has_room_o,
    output logic                         full_o,
    output logic                         empty_o
);

    logic [SLOTS-1:0]            valid_q;
    logic [SLOTS-1:0][TAG_W-1:0] tag_q;
    logic [SLOTS-1:0]            bar_q;
    logic [SLOTS-1:0]            clr;
    logic [IDX_W-1:0]            free_idx;
    logic [CNT_W-1:0]            occ;

    // Pick the lowest-numbered free slot for the next allocation.
    always_comb begin
        free_idx   = '0;
        has_room_o = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_idx   = IDX_W'(i);
                has_room_o = 1'b1;
            end
        end
    end

    // Mark the slots that the current completion releases.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            clr[i] = free_en && valid_q[i] && (tag_q[i] == free_tag);
        end
    end

    // Slot state: allocation sets one slot, completion clears matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            bar_q   <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (alloc_en && (free_idx == IDX_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    tag_q[i]   <= alloc_tag;
                    bar_q[i]   <= alloc_bar;
                end else if (clr[i]) begin
                    valid_q[i] <= 1'b0;
                    bar_q[i]   <= 1'b0;
                end
            end
        end
    end

    // Occupancy and status flags.
    always_comb begin
        occ     = CNT_W'($countones(valid_q));
        full_o  = (SIZE != 0) && (occ == CNT_W'(SIZE));
        empty_o = (occ == '0);
    end

    assign valid_o = valid_q;
    assign tag_o   = tag_q;
    assign bar_o   = bar_q;

    // R3: the pool never takes an allocation when every slot is held.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !(&valid_q));

    // R3: occupancy grows by at most one per cycle.
    a_r3_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(occ) <= int'($past(occ)) + 1));

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot_chk
            // R2: an allocated slot holds the dispatched tag afterwards.
            a_r2_alloc_lands: assert property (@(posedge clk) disable iff (!rst_n)
                (alloc_en && free_idx == IDX_W'(g)) |=>
                    (valid_q[g] && tag_q[g] == $past(alloc_tag)));
            // R10: a released slot is empty after the edge.
            a_r10_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[g] && !(alloc_en && free_idx == IDX_W'(g))) |=> !valid_q[g]);
        end
    endgenerate

endmodule

// File: rtl/lsq_age_scan.sv
// Scans a pool against one query tag. It reports whether the tag is in
// the pool, whether that entry is a fence, and whether any older entry
// (or any older fence) is present. Purely combinational.
// Assumes tags within a pool are unique.
module lsq_age_scan #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned TAG_W = 4
) (
    input  logic [SLOTS-1:0]            valid_i,
    input  logic [SLOTS-1:0][TAG_W-1:0] tag_i,
    input  logic [SLOTS-1:0]            bar_i,
    input  logic [TAG_W-1:0]            q_tag,
    output logic                        hit_o,
    output logic                        hit_bar_o,
    output logic                        older_o,
    output logic                        older_bar_o
);
    import lsq_pkg::*;

    // Compare every held slot with the query tag in parallel.
    always_comb begin
        hit_o       = 1'b0;
        hit_bar_o   = 1'b0;
        older_o     = 1'b0;
        older_bar_o = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (valid_i[i]) begin
                if (tag_i[i] == q_tag) begin
                    hit_o     = 1'b1;
                    hit_bar_o = hit_bar_o | bar_i[i];
                end else if (tag_is_older(32'(tag_i[i]), 32'(q_tag), TAG_W)) begin
                    older_o     = 1'b1;
                    older_bar_o = older_bar_o | bar_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/lsq_order_tracker.sv
// Top of the load/store issue-order tracker. It combines a load pool and a
// store pool, and derives from them the dispatch acceptance and the
// issue-permission answer for one query tag per cycle.
// Assumes tags arrive in program order, that no more than 2^(TAG_W-1)
// are outstanding, and that a tag is never dispatched and completed in
// the same cycle.
module lsq_order_tracker #(
    parameter int unsigned LQ_SIZE  = 4,
    parameter int unsigned SQ_SIZE  = 4,
    parameter int unsigned TAG_W    = 4,
    parameter bit          NO_ALIAS = 1'b0,
    localparam int unsigned LQ_SLOTS = (LQ_SIZE == 0) ? (1 << (TAG_W - 1)) : LQ_SIZE,
    localparam int unsigned SQ_SLOTS = (SQ_SIZE == 0) ? (1 << (TAG_W - 1)) : SQ_SIZE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic             disp_may_load,
    input  logic             disp_may_store,
    input  logic             disp_side_effect,
    output logic             disp_accept,
    input  logic [TAG_W-1:0] qry_tag,
    output logic             qry_ready,
    input  logic             done_valid,
    input  logic [TAG_W-1:0] done_tag,
    output logic             lq_full,
    output logic             sq_full,
    output logic             lq_empty,
    output logic             sq_empty
);

    logic [LQ_SLOTS-1:0]            lq_valid, lq_bar;
    logic [LQ_SLOTS-1:0][TAG_W-1:0] lq_tags;
    logic [SQ_SLOTS-1:0]            sq_valid, sq_bar;
    logic [SQ_SLOTS-1:0][TAG_W-1:0] sq_tags;
    logic lq_room, sq_room;
    logic lq_hit, lq_hit_bar, lq_older, lq_older_bar;
    logic sq_hit, sq_hit_bar, sq_older, sq_older_bar;
    logic ld_block, st_block;

    // Accept only when every pool the operation needs has a free slot.
    always_comb begin
        disp_accept = disp_valid
                    && (!disp_may_load  || lq_room)
                    && (!disp_may_store || sq_room);
    end

    lsq_slot_queue #(.SIZE(LQ_SIZE), .TAG_W(TAG_W)) u_lq (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(disp_accept && disp_may_load), .alloc_tag(disp_tag),
        .alloc_bar(disp_side_effect),
        .free_en(done_valid), .free_tag(done_tag),
        .valid_o(lq_valid), .tag_o(lq_tags), .bar_o(lq_bar),
        .has_room_o(lq_room), .full_o(lq_full), .empty_o(lq_empty)
    );

    lsq_slot_queue #(.SIZE(SQ_SIZE), .TAG_W(TAG_W)) u_sq (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(disp_accept && disp_may_store), .alloc_tag(disp_tag),
        .alloc_bar(disp_side_effect),
        .free_en(done_valid), .free_tag(done_tag),
        .valid_o(sq_valid), .tag_o(sq_tags), .bar_o(sq_bar),
        .has_room_o(sq_room), .full_o(sq_full), .empty_o(sq_empty)
    );

    lsq_age_scan #(.SLOTS(LQ_SLOTS), .TAG_W(TAG_W)) u_lq_scan (
        .valid_i(lq_valid), .tag_i(lq_tags), .bar_i(lq_bar), .q_tag(qry_tag),
        .hit_o(lq_hit), .hit_bar_o(lq_hit_bar),
        .older_o(lq_older), .older_bar_o(lq_older_bar)
    );

    lsq_age_scan #(.SLOTS(SQ_SLOTS), .TAG_W(TAG_W)) u_sq_scan (
        .valid_i(sq_valid), .tag_i(sq_tags), .bar_i(sq_bar), .q_tag(qry_tag),
        .hit_o(sq_hit), .hit_bar_o(sq_hit_bar),
        .older_o(sq_older), .older_bar_o(sq_older_bar)
    );

    // Load-side hold: a fence waits for older loads, younger loads wait
    // for older fences, and older stores hold loads unless no-alias is set.
    always_comb begin
        ld_block = lq_hit && ((lq_hit_bar && lq_older)
                              || lq_older_bar
                              || (!NO_ALIAS && sq_older));
    end

    // Store-side hold: every older load or store, fence or not, blocks.
    always_comb begin
        st_block = sq_hit && (sq_older || lq_older || sq_older_bar
                              || (sq_hit_bar && (sq_older || lq_older)));
    end

    // Issue permission for the queried tag.
    always_comb begin
        qry_ready = (lq_hit || sq_hit) && !ld_block && !st_block;
    end

    // R2: acceptance implies a request was present.
    a_r2_accept_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        disp_accept |-> disp_valid);

    // R2: an accepted store leaves the store pool non-empty.
    a_r2_store_occupies: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_accept && disp_may_store && !done_valid) |=> !sq_empty);

    // R3: a full pool is never reported empty.
    a_r3_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full |-> !lq_empty) and (sq_full |-> !sq_empty));

    // R3: a dispatch needing a full load pool is refused.
    a_r3_reject_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full && disp_may_load) |-> !disp_accept);

endmodule

// File: tb/lsq_order_tracker_bench.sv
module lsq_order_tracker_bench;

    localparam int TW = 4;
    localparam logic [1:0] K_D = 2'd0, K_C = 2'd1, K_Q = 2'd2;

    // Row: kind, tag, load, store, side-effect, exp(main), exp(no-alias), req
    function automatic logic [15:0] row(input logic [1:0] k, input int t,
                                        input bit ml, input bit ms, input bit se,
                                        input bit e, input bit en, input int rq);
        return {k, 4'(t), ml, ms, se, e, en, 5'(rq)};
    endfunction

    localparam int N = 35;
    localparam logic [15:0] VEC [N] = '{
        row(K_D, 0, 1,0,0, 1,1, 2),   // R2 load
        row(K_D, 1, 0,1,0, 1,1, 2),   // R2 store
        row(K_D, 2, 1,0,0, 1,1, 2),
        row(K_Q, 0, 0,0,0, 1,1, 6),   // R6
        row(K_Q, 1, 0,0,0, 0,0, 5),   // R5
        row(K_Q, 2, 0,0,0, 0,1, 7),   // R7
        row(K_C, 0, 0,0,0, 0,0, 10),
        row(K_Q, 1, 0,0,0, 1,1, 5),   // R5
        row(K_D, 3, 0,1,0, 1,1, 2),
        row(K_Q, 3, 0,0,0, 0,0, 4),   // R4
        row(K_C, 1, 0,0,0, 0,0, 10),
        row(K_Q, 3, 0,0,0, 0,0, 5),
        row(K_Q, 2, 0,0,0, 1,1, 7),
        row(K_D, 4, 1,0,1, 1,1, 8),   // R8 load fence
        row(K_D, 5, 1,0,0, 1,1, 8),
        row(K_Q, 5, 0,0,0, 0,0, 8),
        row(K_Q, 4, 0,0,0, 0,0, 8),
        row(K_C, 2, 0,0,0, 0,0, 10),
        row(K_Q, 4, 0,0,0, 0,1, 8),
        row(K_C, 3, 0,0,0, 0,0, 10),
        row(K_Q, 4, 0,0,0, 1,1, 8),
        row(K_C, 4, 0,0,0, 0,0, 10),
        row(K_Q, 5, 0,0,0, 1,1, 8),
        row(K_D, 6, 1,1,1, 1,1, 9),   // R9 full fence
        row(K_D, 7, 0,1,0, 1,1, 9),
        row(K_Q, 7, 0,0,0, 0,0, 9),
        row(K_Q, 6, 0,0,0, 0,0, 9),
        row(K_C, 5, 0,0,0, 0,0, 10),
        row(K_Q, 6, 0,0,0, 1,1, 9),
        row(K_C, 6, 0,0,0, 0,0, 10),  // R10 frees both pools
        row(K_Q, 7, 0,0,0, 1,1, 10),
        row(K_Q, 6, 0,0,0, 0,0, 12),  // R12
        row(K_C, 9, 0,0,0, 0,0, 10),  // R10 unknown tag
        row(K_Q, 7, 0,0,0, 1,1, 10),
        row(K_C, 7, 0,0,0, 0,0, 10)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0, disp_may_load = 1'b0, disp_may_store = 1'b0, disp_side_effect = 1'b0;
    logic [TW-1:0] disp_tag = '0, qry_tag = '0, done_tag = '0;
    logic done_valid = 1'b0;
    logic acc_m, rdy_m, lqf_m, sqf_m, lqe_m, sqe_m;
    logic acc_n, rdy_n, lqf_n, sqf_n, lqe_n, sqe_n;
    logic acc_u, rdy_u, lqf_u, sqf_u, lqe_u, sqe_u;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    lsq_order_tracker #(.LQ_SIZE(4), .SQ_SIZE(4), .TAG_W(TW), .NO_ALIAS(1'b0)) u_lsq_order_tracker (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
        .disp_may_load(disp_may_load), .disp_may_store(disp_may_store),
        .disp_side_effect(disp_side_effect), .disp_accept(acc_m),
        .qry_tag(qry_tag), .qry_ready(rdy_m), .done_valid(done_valid), .done_tag(done_tag),
        .lq_full(lqf_m), .sq_full(sqf_m), .lq_empty(lqe_m), .sq_empty(sqe_m));

    lsq_order_tracker #(.LQ_SIZE(4), .SQ_SIZE(4), .TAG_W(TW), .NO_ALIAS(1'b1)) u_lsq_order_tracker_na (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
        .disp_may_load(disp_may_load), .disp_may_store(disp_may_store),
        .disp_side_effect(disp_side_effect), .disp_accept(acc_n),
        .qry_tag(qry_tag), .qry_ready(rdy_n), .done_valid(done_valid), .done_tag(done_tag),
        .lq_full(lqf_n), .sq_full(sqf_n), .lq_empty(lqe_n), .sq_empty(sqe_n));

    lsq_order_tracker #(.LQ_SIZE(0), .SQ_SIZE(4), .TAG_W(TW), .NO_ALIAS(1'b0)) u_lsq_order_tracker_ub (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
        .disp_may_load(disp_may_load), .disp_may_store(disp_may_store),
        .disp_side_effect(disp_side_effect), .disp_accept(acc_u),
        .qry_tag(qry_tag), .qry_ready(rdy_u), .done_valid(done_valid), .done_tag(done_tag),
        .lq_full(lqf_u), .sq_full(sqf_u), .lq_empty(lqe_u), .sq_empty(sqe_u));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        disp_valid = 1'b0;
        done_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drv_disp(input int t, input bit ml, input bit ms, input bit se,
                            output logic am, output logic an, output logic au);
        @(negedge clk);
        disp_valid = 1'b1; disp_tag = TW'(t);
        disp_may_load = ml; disp_may_store = ms; disp_side_effect = se;
        #2;
        am = acc_m; an = acc_n; au = acc_u;
        @(posedge clk);
        #1;
        disp_valid = 1'b0; disp_may_load = 1'b0; disp_may_store = 1'b0; disp_side_effect = 1'b0;
    endtask

    task automatic drv_done(input int t);
        @(negedge clk);
        done_valid = 1'b1; done_tag = TW'(t);
        @(posedge clk);
        #1;
        done_valid = 1'b0;
    endtask

    task automatic drv_qry(input int t, output logic rm, output logic rn);
        @(negedge clk);
        qry_tag = TW'(t);
        #2;
        rm = rdy_m; rn = rdy_n;
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a0, a1, a2, r0, r1;
        do_reset();
        // R1: reset state
        chk("R1 lq_empty", lqe_m, 1'b1);
        chk("R1 sq_empty", sqe_m, 1'b1);
        chk("R1 lq_full", lqf_m, 1'b0);
        chk("R1 sq_full", sqf_m, 1'b0);
        drv_qry(0, r0, r1);
        chk("R1 ready idle", r0, 1'b0);

        // Table walk
        for (int i = 0; i < N; i++) begin
            logic [15:0] v;
            string tagname;
            v = VEC[i];
            tagname = $sformatf("R%0d row %0d", v[4:0], i);
            case (v[15:14])
                K_D: begin
                    drv_disp(int'(v[13:10]), v[9], v[8], v[7], a0, a1, a2);
                    chk(tagname, a0, v[6]);
                    chk({tagname, " no-alias"}, a1, v[5]);
                end
                K_C: drv_done(int'(v[13:10]));
                default: begin
                    drv_qry(int'(v[13:10]), r0, r1);
                    chk(tagname, r0, v[6]);
                    chk({tagname, " no-alias"}, r1, v[5]);
                end
            endcase
        end
        @(negedge clk);
        chk("R10 lq drained", lqe_m, 1'b1);
        chk("R10 sq drained", sqe_m, 1'b1);

        // R11: wrapped tags, 14 older than 0
        drv_disp(14, 1, 0, 0, a0, a1, a2);
        drv_disp(0, 0, 1, 0, a0, a1, a2);
        drv_qry(0, r0, r1);
        chk("R11 store after wrap waits", r0, 1'b0);
        drv_qry(14, r0, r1);
        chk("R11 wrapped older load ready", r0, 1'b1);
        drv_done(14);
        drv_qry(0, r0, r1);
        chk("R11 store freed after wrap", r0, 1'b1);
        drv_done(0);

        // R3: capacity, rejection, unbounded pool
        do_reset();
        for (int t = 0; t < 4; t++) begin
            drv_disp(t, 1, 0, 0, a0, a1, a2);
            chk("R3 fill accept", a0, 1'b1);
        end
        @(negedge clk);
        chk("R3 lq_full at size", lqf_m, 1'b1);
        chk("R3 size zero never full", lqf_u, 1'b0);
        drv_disp(4, 1, 0, 0, a0, a1, a2);
        chk("R3 reject on full", a0, 1'b0);
        chk("R3 unbounded accepts", a2, 1'b1);
        drv_disp(5, 1, 1, 0, a0, a1, a2);
        chk("R3 both-pool reject", a0, 1'b0);
        drv_disp(6, 0, 0, 0, a0, a1, a2);
        chk("R2 no-slot op accepted", a0, 1'b1);
        @(negedge clk);
        chk("R3 rejected op left sq empty", sqe_m, 1'b1);
        chk("R2 no-slot op keeps lq full", lqf_m, 1'b1);
        drv_disp(7, 0, 1, 0, a0, a1, a2);
        chk("R3 store accepted with lq full", a0, 1'b1);
        @(negedge clk);
        chk("R2 store occupies sq", sqe_m, 1'b0);
        drv_done(7);
        @(negedge clk);
        chk("R10 store freed", sqe_m, 1'b1);
        drv_done(0);
        @(negedge clk);
        chk("R3 full drops at size-1", lqf_m, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule